// File: doc/BRIEF.md
# Windowed Translation Request Coalescer

This block sits in front of a lower-level translation lookaside buffer and gathers address-translation requests from several upstream requesters into groups, so that one downstream lookup can serve many requests. Each request brings a virtual address, a read/write mode, a prefetch flag, an issue timestamp, a count of how many original requests it already stands for, and the ID of the upstream port it came in on.

The issue timestamp (or the current cycle count when the timestamp is zero) is divided by a window length to give a bucket number. The low bits of that number select a bucket slot, and the full number is kept as the slot's tag. Within its bucket, a request is compared with the head of each existing group, in the order the groups were opened. It joins the first group whose head has the same virtual page and the same mode. Otherwise it opens a new group. Heads accumulate the represented-request counts of the non-prefetch requests that join them.

The stored groups are read through a combinational read port by the issue logic that follows. That logic releases a whole bucket slot with a free strobe once it has drained it. When storage cannot take a request, the block holds `in_ready` low and does not drop the request. One cycle after any accepted request, a pending pulse tells the issue scheduler to run.

Top module: `xlat_window_coalescer`

## Requirements
- R1: The bucket number is the effective timestamp divided by WINDOW (default 8). Its value modulo NUM_BUCKETS (default 4) selects the slot, and the full bucket number is stored as the slot's tag. A request whose slot is occupied under a different tag sees `in_ready` low.
- R2: When `in_time` is 0, the effective timestamp is the cycle count. That count is 0 on the first clock edge after reset is released and rises by one at every edge.
- R3: A request is compared only with the head (member 0) of each group in its bucket, from group 0 upward. It joins the lowest-numbered matching group and is stored in that group's next member slot.
- R4: A head matches when both of these hold: the virtual page number (`in_vaddr` shifted right by PAGE_BITS, default 12) is equal, and `in_write` is equal. If no head matches, the request opens the next group number and becomes its head.
- R5: While `cfg_no_merge` is 1, every accepted request opens a new group.
- R6: When a request with `in_prefetch` = 0 joins a group, its effective count is added to the head's stored count. A joining prefetch request leaves the head's count unchanged.
- R7: An `in_count` of 0 is stored and added as 1. Any other value is used as given.
- R8: `stat_uncoal` rises by one for each accepted request with `in_prefetch` = 0. `stat_coal` rises by one for each accepted request that opens a group. Both change one edge after acceptance.
- R9: Every stored member keeps its address, mode, prefetch flag, effective count and `in_port`, and these can be read back through the read port. `rd_valid` is 1 exactly for bucket, group and member slots that are occupied.
- R10: `in_ready` is low, and nothing changes, in either of these cases: the matching group already holds NUM_MEMBERS (default 4) members, or no head matches and the bucket already holds NUM_GROUPS (default 4) groups.
- R11: `pend_issue` is 1 in exactly the cycle after each edge at which a request was accepted.
- R12: A `free_valid` strobe empties slot `free_slot` at the next edge. A request that targets the slot being freed in the same cycle sees `in_ready` low.
- R13: After reset all slots are empty, both counters and `pend_issue` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_no_merge | input | 1 | Forces every request to open its own group |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_vaddr | input | VA_W | Virtual address |
| in_write | input | 1 | Access mode, 1 = write |
| in_prefetch | input | 1 | Request is a prefetch |
| in_time | input | TIME_W | Issue timestamp, 0 = unset |
| in_count | input | CNT_W | Represented-request count, 0 = one |
| in_port | input | PORT_W | Upstream port ID for the return path |
| free_valid | input | 1 | Release a bucket slot |
| free_slot | input | log2(NUM_BUCKETS) | Slot to release |
| rd_slot | input | log2(NUM_BUCKETS) | Read port: bucket slot |
| rd_group | input | log2(NUM_GROUPS) | Read port: group |
| rd_member | input | log2(NUM_MEMBERS) | Read port: member |
| rd_valid | output | 1 | Addressed member is occupied |
| rd_tag | output | TIME_W | Bucket number held by the slot |
| rd_vaddr | output | VA_W | Member address |
| rd_write | output | 1 | Member mode |
| rd_prefetch | output | 1 | Member prefetch flag |
| rd_count | output | CNT_W | Member count (accumulated total for a head) |
| rd_port | output | PORT_W | Member return port ID |
| rd_groups | output | log2(NUM_GROUPS+1) | Groups open in the slot (0 if empty) |
| rd_len | output | log2(NUM_MEMBERS+1) | Members in the addressed group (0 if none) |
| pend_issue | output | 1 | Scheduler wake-up, one cycle after an accept |
| stat_uncoal | output | STAT_W | Accepted non-prefetch requests |
| stat_coal | output | STAT_W | Groups opened |

## Verification
The hardest behaviour to reach from the ports is the first-match ordering. With distinct heads, at most one group can ever match. So the stimulus first sets `cfg_no_merge` to build two groups whose heads are the same page and mode, then clears it and sends a third matching request, which must land in group 0. The full conditions are also deliberate targets: a group is filled to its member limit with a mix of prefetch and counted requests, and a bucket is driven to its group limit. A request with a new window tag and a free strobe in the same cycle as a request exercise the slot-conflict paths. Timestamps of zero tie bucket selection to the cycle count, which the reference model tracks independently.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_JOIN = 2'd1,
    ACT_OPEN = 2'd2
  } coal_act_e;
endpackage

// File: rtl/coal_bucket_sel.sv
module coal_bucket_sel #(
  parameter int TIME_W = 32,
  parameter int WINDOW = 8,
  parameter int BKT_W  = 2
) (
  input  logic [TIME_W-1:0] cur_cycle,
  input  logic [TIME_W-1:0] req_time,
  output logic [TIME_W-1:0] tick,
  output logic [BKT_W-1:0]  slot
);
  logic [TIME_W-1:0] ts_eff;

  always_comb begin
    ts_eff = (req_time == '0) ? cur_cycle : req_time;
    tick   = ts_eff / TIME_W'(WINDOW);
    slot   = tick[BKT_W-1:0];
  end
endmodule

// File: rtl/coal_head_match.sv
module coal_head_match #(
  parameter int NUM_GROUPS = 4,
  parameter int VPN_W      = 20,
  parameter int GI_W       = 2,
  parameter int GN_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             no_merge,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_wr,
  input  logic [VPN_W-1:0] head_vpn [NUM_GROUPS],
  input  logic             head_wr  [NUM_GROUPS],
  input  logic [GN_W-1:0]  n_groups,
  output logic             hit,
  output logic [GI_W-1:0]  hit_idx
);
  logic [NUM_GROUPS-1:0] eq;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cmp
    assign eq[g] = (GN_W'(g) < n_groups) && (head_vpn[g] == req_vpn) &&
                   (head_wr[g] == req_wr);
  end

  // lowest index wins: scan downward so the last write is the lowest match
  always_comb begin
    hit_idx = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (eq[g]) hit_idx = GI_W'(g);
    end
    hit = (|eq) && !no_merge;
  end

  // R4: a reported hit points at an open group whose head agrees on page and mode
  a_r4_hit_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (head_vpn[hit_idx] == req_vpn && head_wr[hit_idx] == req_wr &&
             GN_W'(hit_idx) < n_groups));

  // R5: merging disabled never reports a hit
  a_r5_no_merge: assert property (@(posedge clk) disable iff (!rst_n)
    no_merge |-> !hit);
endmodule

// File: rtl/coal_stat_ctr.sv
module coal_stat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  logic [W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign value = cnt_q;
endmodule

// File: rtl/xlat_window_coalescer.sv
module xlat_window_coalescer
  import coal_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int TIME_W      = 32,
  parameter int WINDOW      = 8,
  parameter int NUM_BUCKETS = 4,
  parameter int NUM_GROUPS  = 4,
  parameter int NUM_MEMBERS = 4,
  parameter int CNT_W       = 8,
  parameter int PORT_W      = 3,
  parameter int STAT_W      = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_no_merge,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [VA_W-1:0]                in_vaddr,
  input  logic                           in_write,
  input  logic                           in_prefetch,
  input  logic [TIME_W-1:0]              in_time,
  input  logic [CNT_W-1:0]               in_count,
  input  logic [PORT_W-1:0]              in_port,
  input  logic                           free_valid,
  input  logic [$clog2(NUM_BUCKETS)-1:0] free_slot,
  input  logic [$clog2(NUM_BUCKETS)-1:0] rd_slot,
  input  logic [$clog2(NUM_GROUPS)-1:0]  rd_group,
  input  logic [$clog2(NUM_MEMBERS)-1:0] rd_member,
  output logic                           rd_valid,
  output logic [TIME_W-1:0]              rd_tag,
  output logic [VA_W-1:0]                rd_vaddr,
  output logic                           rd_write,
  output logic                           rd_prefetch,
  output logic [CNT_W-1:0]               rd_count,
  output logic [PORT_W-1:0]              rd_port,
  output logic [$clog2(NUM_GROUPS+1)-1:0]  rd_groups,
  output logic [$clog2(NUM_MEMBERS+1)-1:0] rd_len,
  output logic                           pend_issue,
  output logic [STAT_W-1:0]              stat_uncoal,
  output logic [STAT_W-1:0]              stat_coal
);
  localparam int BKT_W = $clog2(NUM_BUCKETS);
  localparam int GI_W  = $clog2(NUM_GROUPS);
  localparam int GN_W  = $clog2(NUM_GROUPS + 1);
  localparam int MI_W  = $clog2(NUM_MEMBERS);
  localparam int ML_W  = $clog2(NUM_MEMBERS + 1);
  localparam int VPN_W = VA_W - PAGE_BITS;

  // control state (reset)
  logic [TIME_W-1:0]    cyc_q;
  logic                 pend_q;
  logic [NUM_BUCKETS-1:0] bkt_used_q;
  logic [TIME_W-1:0]    bkt_tag_q [NUM_BUCKETS];
  logic [GN_W-1:0]      bkt_ng_q  [NUM_BUCKETS];
  logic [ML_W-1:0]      grp_len_q [NUM_BUCKETS][NUM_GROUPS];

  // member payload (no reset, qualified by control state)
  logic [VA_W-1:0]   mem_va_q   [NUM_BUCKETS][NUM_GROUPS][NUM_MEMBERS];
  logic              mem_wr_q   [NUM_BUCKETS][NUM_GROUPS][NUM_MEMBERS];
  logic              mem_pf_q   [NUM_BUCKETS][NUM_GROUPS][NUM_MEMBERS];
  logic [CNT_W-1:0]  mem_cnt_q  [NUM_BUCKETS][NUM_GROUPS][NUM_MEMBERS];
  logic [PORT_W-1:0] mem_port_q [NUM_BUCKETS][NUM_GROUPS][NUM_MEMBERS];

  // ---------------- bucket selection ----------------
  logic [TIME_W-1:0] tick;
  logic [BKT_W-1:0]  slot;

  coal_bucket_sel #(.TIME_W(TIME_W), .WINDOW(WINDOW), .BKT_W(BKT_W)) u_sel (
    .cur_cycle (cyc_q),
    .req_time  (in_time),
    .tick      (tick),
    .slot      (slot)
  );

  logic bkt_hit, bkt_empty, free_clash;
  logic [GN_W-1:0] ng;

  always_comb begin
    bkt_hit    = bkt_used_q[slot] && (bkt_tag_q[slot] == tick);
    bkt_empty  = !bkt_used_q[slot];
    free_clash = free_valid && (free_slot == slot);
    ng         = bkt_hit ? bkt_ng_q[slot] : '0;
  end

  // ---------------- head comparison ----------------
  logic [VPN_W-1:0] head_vpn [NUM_GROUPS];
  logic             head_wr  [NUM_GROUPS];
  logic             m_hit;
  logic [GI_W-1:0]  m_idx;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_head
    assign head_vpn[g] = mem_va_q[slot][g][0][VA_W-1:PAGE_BITS];
    assign head_wr[g]  = mem_wr_q[slot][g][0];
  end

  coal_head_match #(
    .NUM_GROUPS(NUM_GROUPS), .VPN_W(VPN_W), .GI_W(GI_W), .GN_W(GN_W)
  ) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .no_merge (cfg_no_merge),
    .req_vpn  (in_vaddr[VA_W-1:PAGE_BITS]),
    .req_wr   (in_write),
    .head_vpn (head_vpn),
    .head_wr  (head_wr),
    .n_groups (ng),
    .hit      (m_hit),
    .hit_idx  (m_idx)
  );

  // ---------------- placement decision ----------------
  coal_act_e        act;
  logic [GI_W-1:0]  tgt_g;
  logic [MI_W-1:0]  tgt_m;
  logic [ML_W-1:0]  tgt_len;
  logic [CNT_W-1:0] eff_cnt;
  logic             accept;

  always_comb begin
    act     = ACT_NONE;
    tgt_g   = '0;
    tgt_m   = '0;
    tgt_len = grp_len_q[slot][m_idx];
    eff_cnt = (in_count == '0) ? CNT_W'(1) : in_count;
    if (!free_clash && (bkt_hit || bkt_empty)) begin
      if (m_hit) begin
        if (tgt_len < ML_W'(NUM_MEMBERS)) begin
          act   = ACT_JOIN;
          tgt_g = m_idx;
          tgt_m = MI_W'(tgt_len);
        end
      end else if (ng < GN_W'(NUM_GROUPS)) begin
        act   = ACT_OPEN;
        tgt_g = GI_W'(ng);
      end
    end
    in_ready = (act != ACT_NONE);
    accept   = in_valid && in_ready;
  end

  // ---------------- control registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q      <= '0;
      pend_q     <= 1'b0;
      bkt_used_q <= '0;
      for (int b = 0; b < NUM_BUCKETS; b++) begin
        bkt_tag_q[b] <= '0;
        bkt_ng_q[b]  <= '0;
        for (int g = 0; g < NUM_GROUPS; g++) grp_len_q[b][g] <= '0;
      end
    end else begin
      cyc_q  <= cyc_q + TIME_W'(1);
      pend_q <= accept;
      if (free_valid) bkt_used_q[free_slot] <= 1'b0;
      if (accept) begin
        if (act == ACT_OPEN) begin
          if (bkt_empty) begin
            bkt_used_q[slot] <= 1'b1;
            bkt_tag_q[slot]  <= tick;
          end
          bkt_ng_q[slot]         <= ng + GN_W'(1);
          grp_len_q[slot][tgt_g] <= ML_W'(1);
        end else begin
          grp_len_q[slot][tgt_g] <= tgt_len + ML_W'(1);
        end
      end
    end
  end

  // ---------------- payload registers ----------------
  always_ff @(posedge clk) begin
    if (accept) begin
      mem_va_q[slot][tgt_g][tgt_m]   <= in_vaddr;
      mem_wr_q[slot][tgt_g][tgt_m]   <= in_write;
      mem_pf_q[slot][tgt_g][tgt_m]   <= in_prefetch;
      mem_cnt_q[slot][tgt_g][tgt_m]  <= eff_cnt;
      mem_port_q[slot][tgt_g][tgt_m] <= in_port;
      if (act == ACT_JOIN && !in_prefetch)
        mem_cnt_q[slot][tgt_g][0] <= mem_cnt_q[slot][tgt_g][0] + eff_cnt;
    end
  end

  // ---------------- statistics ----------------
  coal_stat_ctr #(.W(STAT_W)) u_uncoal (
    .clk(clk), .rst_n(rst_n), .inc(accept && !in_prefetch), .value(stat_uncoal)
  );
  coal_stat_ctr #(.W(STAT_W)) u_coal (
    .clk(clk), .rst_n(rst_n), .inc(accept && (act == ACT_OPEN)), .value(stat_coal)
  );

  assign pend_issue = pend_q;

  // ---------------- read port ----------------
  always_comb begin
    rd_groups   = bkt_used_q[rd_slot] ? bkt_ng_q[rd_slot] : '0;
    rd_len      = (GN_W'(rd_group) < rd_groups) ? grp_len_q[rd_slot][rd_group] : '0;
    rd_valid    = ML_W'(rd_member) < rd_len;
    rd_tag      = bkt_tag_q[rd_slot];
    rd_vaddr    = mem_va_q[rd_slot][rd_group][rd_member];
    rd_write    = mem_wr_q[rd_slot][rd_group][rd_member];
    rd_prefetch = mem_pf_q[rd_slot][rd_group][rd_member];
    rd_count    = mem_cnt_q[rd_slot][rd_group][rd_member];
    rd_port     = mem_port_q[rd_slot][rd_group][rd_member];
  end

  // ---------------- assertions ----------------
  // R11: the wake-up pulse only follows an accepted request
  a_r11_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pend_issue |-> $past(in_valid && in_ready));

  // R8: the request counter only moves after a non-prefetch accept
  a_r8_uncoal_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_uncoal != $past(stat_uncoal)) |->
      ($past(in_valid && in_ready && !in_prefetch) &&
       stat_uncoal == $past(stat_uncoal) + STAT_W'(1)));

  // R12: a freed slot is empty after the edge
  a_r12_free_empties: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |=> !bkt_used_q[$past(free_slot)]);

  // R1: an accepted request leaves its slot occupied under its bucket number
  a_r1_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (bkt_used_q[$past(slot)] && bkt_tag_q[$past(slot)] == $past(tick)));

  // R10: occupancy never exceeds the configured bounds
  for (genvar b = 0; b < NUM_BUCKETS; b++) begin : g_bnd_b
    a_r10_groups_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bkt_ng_q[b] <= GN_W'(NUM_GROUPS));
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bnd_g
      a_r10_members_bound: assert property (@(posedge clk) disable iff (!rst_n)
        grp_len_q[b][g] <= ML_W'(NUM_MEMBERS));
    end
  end
endmodule

// File: tb/test_xlat_window_coalescer.sv
`timescale 1ns/1ps
module test_xlat_window_coalescer;
  localparam int NB = 4, NG = 4, NM = 4, WIN = 8, PB = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_no_merge, in_valid, in_ready, in_write, in_prefetch, free_valid;
  logic [31:0] in_vaddr, in_time;
  logic [7:0]  in_count;
  logic [2:0]  in_port;
  logic [1:0]  free_slot, rd_slot, rd_group, rd_member;
  logic rd_valid, rd_write, rd_prefetch, pend_issue;
  logic [31:0] rd_tag, rd_vaddr;
  logic [7:0]  rd_count;
  logic [2:0]  rd_port, rd_groups, rd_len;
  logic [15:0] stat_uncoal, stat_coal;

  always #4 clk = ~clk;

  xlat_window_coalescer i_xlat_window_coalescer (
    .clk(clk), .rst_n(rst_n), .cfg_no_merge(cfg_no_merge),
    .in_valid(in_valid), .in_ready(in_ready), .in_vaddr(in_vaddr),
    .in_write(in_write), .in_prefetch(in_prefetch), .in_time(in_time),
    .in_count(in_count), .in_port(in_port), .free_valid(free_valid),
    .free_slot(free_slot), .rd_slot(rd_slot), .rd_group(rd_group),
    .rd_member(rd_member), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_vaddr(rd_vaddr), .rd_write(rd_write), .rd_prefetch(rd_prefetch),
    .rd_count(rd_count), .rd_port(rd_port), .rd_groups(rd_groups),
    .rd_len(rd_len), .pend_issue(pend_issue), .stat_uncoal(stat_uncoal),
    .stat_coal(stat_coal)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // reference model
  int m_used [NB];
  int m_tag  [NB];
  int m_ng   [NB];
  int m_len  [NB][NG];
  int unsigned m_va [NB][NG][NM];
  int m_wr  [NB][NG][NM];
  int m_pf  [NB][NG][NM];
  int m_cnt [NB][NG][NM];
  int m_prt [NB][NG][NM];
  int m_cyc = 0, m_unc = 0, m_coa = 0, m_pend = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step(input string rq, input bit v, input int unsigned va,
                      input bit wr, input bit pf, input int ts, input int cnt,
                      input int prt, input bit fv, input int fs);
    int tse, tk, s, ng, kind, tg, tm, found, ec;
    bit bhit;
    in_valid = v; in_vaddr = va; in_write = wr; in_prefetch = pf;
    in_time = ts; in_count = cnt[7:0]; in_port = prt[2:0];
    free_valid = fv; free_slot = fs[1:0];
    #1;
    tse  = (ts == 0) ? m_cyc : ts;
    tk   = tse / WIN;
    s    = tk % NB;
    bhit = m_used[s] != 0 && m_tag[s] == tk;
    ng   = bhit ? m_ng[s] : 0;
    kind = 0; tg = 0; tm = 0; found = -1;
    ec   = (cnt == 0) ? 1 : cnt;
    if (!(fv && fs == s) && (bhit || m_used[s] == 0)) begin
      if (!cfg_no_merge)
        for (int g = 0; g < ng; g++)
          if (found < 0 && (m_va[s][g][0] >> PB) == (va >> PB) && m_wr[s][g][0] == wr)
            found = g;
      if (found >= 0) begin
        if (m_len[s][found] < NM) begin kind = 1; tg = found; tm = m_len[s][found]; end
      end else if (ng < NG) begin
        kind = 2; tg = ng;
      end
    end
    chk(in_ready == (kind != 0), rq, "in_ready", in_ready, kind != 0);
    chk(stat_uncoal == m_unc, "R8", "stat_uncoal", stat_uncoal, m_unc);
    chk(stat_coal == m_coa, "R8", "stat_coal", stat_coal, m_coa);
    chk(pend_issue == m_pend, "R11", "pend_issue", pend_issue, m_pend);
    @(posedge clk);
    if (fv) m_used[fs] = 0;
    m_pend = (v && kind != 0) ? 1 : 0;
    if (v && kind != 0) begin
      if (kind == 2) begin
        if (!bhit) begin m_used[s] = 1; m_tag[s] = tk; end
        m_ng[s] = ng + 1;
        m_len[s][tg] = 1;
        m_coa++;
      end else begin
        m_len[s][tg]++;
        if (!pf) m_cnt[s][tg][0] += ec;
      end
      m_va[s][tg][tm] = va; m_wr[s][tg][tm] = wr; m_pf[s][tg][tm] = pf;
      m_cnt[s][tg][tm] = ec; m_prt[s][tg][tm] = prt;
      if (!pf) m_unc++;
    end
    m_cyc++;
    @(negedge clk);
    in_valid = 0; free_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("R13", 0, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask

  // storage sweep through the read port, kept inside the low clock phase
  task automatic sweep();
    bit ev;
    for (int s = 0; s < NB; s++)
      for (int g = 0; g < NG; g++)
        for (int m = 0; m < NM; m++) begin
          rd_slot = s[1:0]; rd_group = g[1:0]; rd_member = m[1:0];
          #0.02;
          ev = m_used[s] != 0 && g < m_ng[s] && m < m_len[s][g];
          chk(rd_valid == ev, "R9", "rd_valid", rd_valid, ev);
          if (g == 0 && m == 0)
            chk(rd_groups == (m_used[s] != 0 ? m_ng[s] : 0), "R9", "rd_groups",
                rd_groups, m_used[s] != 0 ? m_ng[s] : 0);
          if (ev) begin
            chk(rd_tag == m_tag[s], "R1", "rd_tag", rd_tag, m_tag[s]);
            chk(rd_vaddr == m_va[s][g][m], "R3", "rd_vaddr", rd_vaddr, m_va[s][g][m]);
            chk(rd_write == m_wr[s][g][m], "R4", "rd_write", rd_write, m_wr[s][g][m]);
            chk(rd_prefetch == m_pf[s][g][m], "R9", "rd_prefetch", rd_prefetch, m_pf[s][g][m]);
            chk(rd_count == m_cnt[s][g][m], "R6", "rd_count", rd_count, m_cnt[s][g][m]);
            chk(rd_port == m_prt[s][g][m], "R9", "rd_port", rd_port, m_prt[s][g][m]);
          end
        end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_used[b] = 0; m_tag[b] = 0; m_ng[b] = 0;
      for (int g = 0; g < NG; g++) m_len[b][g] = 0;
    end
    rst_n = 0; cfg_no_merge = 0; in_valid = 0; in_vaddr = 0; in_write = 0;
    in_prefetch = 0; in_time = 0; in_count = 0; in_port = 0;
    free_valid = 0; free_slot = 0; rd_slot = 0; rd_group = 0; rd_member = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    step("R13", 0, 32'h1000_0000, 0, 0, 100, 0, 0, 0, 0);
    sweep();
    // same page/mode in one window: R7 default count, R6 accumulate
    step("R7",  1, 32'h1000_0010, 0, 0, 100, 0, 1, 0, 0);
    step("R6",  1, 32'h1000_0FF0, 0, 0, 102, 0, 2, 0, 0);
    step("R6",  1, 32'h1000_0020, 0, 0, 100, 5, 3, 0, 0);
    // R4 other page, other mode
    step("R4",  1, 32'h2000_0000, 0, 0, 103, 0, 4, 0, 0);
    step("R4",  1, 32'h1000_0000, 1, 0, 100, 2, 5, 0, 0);
    // R6 prefetch joiner leaves head count and R8 counter alone
    step("R6",  1, 32'h1000_0030, 0, 1, 101, 4, 6, 0, 0);
    // R10 member limit reached
    step("R10", 1, 32'h1000_0040, 0, 0, 100, 0, 7, 0, 0);
    // R1 other window mapping to the same slot
    step("R1",  1, 32'h1000_0040, 0, 0, 132, 0, 7, 0, 0);
    sweep();
    // R5 forced separate groups, then R3 first-match ordering
    cfg_no_merge = 1;
    step("R5",  1, 32'h3000_0100, 0, 0, 108, 0, 1, 0, 0);
    step("R5",  1, 32'h3000_0200, 0, 0, 109, 3, 2, 0, 0);
    cfg_no_merge = 0;
    step("R3",  1, 32'h3000_0300, 0, 0, 110, 2, 3, 0, 0);
    step("R4",  1, 32'h4000_0000, 0, 0, 111, 0, 4, 0, 0);
    step("R4",  1, 32'h5000_0000, 0, 0, 112, 0, 5, 0, 0);
    // R10 group limit reached
    step("R10", 1, 32'h6000_0000, 0, 0, 113, 0, 6, 0, 0);
    idle(1);
    sweep();
    // R12 free clashes with a request to the same slot, then slot reuse
    step("R12", 1, 32'h7000_0000, 0, 0, 100, 0, 1, 1, 0);
    step("R12", 1, 32'h7000_0000, 0, 0, 100, 0, 1, 0, 0);
    step("R12", 0, 0, 0, 0, 1, 0, 0, 1, 1);
    // R2 timestamps taken from the cycle count
    step("R2",  1, 32'h8000_0010, 0, 0, 0, 0, 2, 0, 0);
    step("R2",  1, 32'h8000_0020, 0, 0, 0, 0, 3, 0, 0);
    step("R2",  1, 32'h8000_0030, 1, 0, 0, 0, 4, 0, 0);
    for (int i = 0; i < 12; i++)
      step("R2", 1, 32'h9000_0000 + i * 32'h10, 0, 0, 0, 1, i % 8, 0, 0);
    idle(2);
    sweep();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule